// File: doc/BRIEF.md
# Carrier Recovery Loop with Acquisition Sweep

This block recovers the carrier phase and frequency in a digital QPSK receiver. Real intermediate-frequency samples in offset binary enter with a valid strobe. A quadrant oscillator, driven by a phase accumulator, mixes each sample down to in-phase (I) and quadrature (Q) products. A two-tap boxcar then removes the image at twice the carrier.

A Costas phase detector turns each filtered I/Q pair into a phase error. A proportional-integral filter integrates that error and steers the oscillator frequency word. While no carrier has been found, a triangle sweep moves the frequency offset back and forth between two symmetric limits to search the uncertainty range. A lock detector averages a diagonal-energy metric with hysteresis. It raises the lock flag, which stops the sweep, and it clears the flag, which lets the sweep resume. The current frequency word is brought out so that downstream logic can see the carrier offset estimate.

Top module: `carrier_loop`

## Requirements
- R1: A sample is converted as x = sample_i − 32 (6-bit offset binary, bit 5 the MSB). The oscillator quadrant is phase bits [15:14]. Quadrant 0 gives (I,Q) products (x,0), quadrant 1 gives (0,−x), quadrant 2 gives (−x,0) and quadrant 3 gives (0,x).
- R2: i_o and q_o are the sum of the current and the previous product of the same channel. iq_valid_o is high for one cycle, two clock edges after the edge that samples sample_valid_i.
- R3: The phase accumulator starts at 0 after reset. It adds freq_o on each valid sample and holds when no sample is valid, so the quadrant depends only on the number of valid samples.
- R4: freq_o is 16384 plus the sweep offset plus the loop-filter output, taken modulo 2^16.
- R5: For each filtered pair, the error is e = sgn(I)·Q − sgn(Q)·I, with sgn(0) = 0. The loop output becomes 4·e + Σe, where the sum covers all errors since reset, and it appears on freq_o four edges after the sample edge. It holds between updates.
- R6: While unlocked, the sweep offset starts at 0 and moves by 16 on each valid sample. It reverses direction on reaching +128 or −128.
- R7: While lock_o is high, the sweep offset does not change. Once lock_o has fallen, the next valid sample moves it again, continuing in the same direction.
- R8: The average is updated on each filtered pair as a ← a + ((m − a) >>> 1), with m = 2·min(|I|,|Q|). lock_o rises after 4 consecutive updates with a ≥ 24. An update with a < 24 restarts the count.
- R9: When lock_o is high, an update that leaves a < 8 clears lock_o.
- R10: After reset, i_o = 0, q_o = 0, iq_valid_o = 0, lock_o = 0 and freq_o = 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 6 | IF sample, offset binary |
| sample_valid_i | input | 1 | Sample strobe |
| i_o | output | 8 | Filtered in-phase value, signed |
| q_o | output | 8 | Filtered quadrature value, signed |
| iq_valid_o | output | 1 | New I/Q pair |
| lock_o | output | 1 | Carrier lock flag |
| freq_o | output | 16 | Oscillator frequency word |

## Verification
The block's results fall due at fixed latencies after the edge that samples a valid input:
- The sweep offset, and with it freq_o, moves on that same edge.
- i_o, q_o and iq_valid_o follow one edge later.
- The error and the lock state update on the edge after that.
- The loop-filter term reaches freq_o on the fourth edge.

The bench drives inputs on falling edges and spaces each sample six cycles from the next, so every stage has settled before the next stimulus. It samples the I/Q outputs on the falling edge right after their update, which proves the two-edge latency. The stimulus patterns are chosen so that the I/Q values, the errors, the average and the sweep position can each be worked out exactly from the requirements.

// File: rtl/cl_pkg.sv
`timescale 1ns/1ps
package cl_pkg;
  typedef enum logic [1:0] {QD_0, QD_90, QD_180, QD_270} quad_e;
endpackage

// File: rtl/cl_nco_mix.sv
`timescale 1ns/1ps
module cl_nco_mix import cl_pkg::*; #(
  parameter int IN_W = 6,
  parameter int PW   = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IN_W-1:0]        sample_i,
  input  logic                   valid_i,
  input  logic [PW-1:0]          freq_i,
  output logic signed [IN_W:0]   mix_i_o,
  output logic signed [IN_W:0]   mix_q_o,
  output logic                   mix_vld_o
);
  localparam logic signed [IN_W:0] MID = (IN_W+1)'(1 << (IN_W-1));

  logic [PW-1:0]        phase_q;
  logic signed [IN_W:0] x, xn, mi, mq;
  quad_e                quad;

  assign x    = $signed({1'b0, sample_i}) - MID;
  assign xn   = -x;
  assign quad = quad_e'(phase_q[PW-1:PW-2]);

  always_comb begin
    mi = '0;
    mq = '0;
    unique case (quad)
      QD_0:   mi = x;
      QD_90:  mq = xn;
      QD_180: mi = xn;
      QD_270: mq = x;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      mix_i_o   <= '0;
      mix_q_o   <= '0;
      mix_vld_o <= 1'b0;
    end else begin
      mix_vld_o <= valid_i;
      if (valid_i) begin
        phase_q <= phase_q + freq_i;
        mix_i_o <= mi;
        mix_q_o <= mq;
      end
    end
  end

  // R3: phase moves only on a valid sample
  a_r3_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase_q));
  // R1: quadrant mixer never drives both products
  a_r1_one_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_vld_o |-> (mix_i_o == '0 || mix_q_o == '0));
endmodule

// File: rtl/cl_boxcar2.sv
`timescale 1ns/1ps
module cl_boxcar2 #(
  parameter int W_IN  = 7,
  parameter int W_OUT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [W_IN-1:0]  d_i,
  input  logic                    vld_i,
  output logic signed [W_OUT-1:0] y_o
);
  logic signed [W_IN-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      y_o    <= '0;
    end else if (vld_i) begin
      prev_q <= d_i;
      y_o    <= W_OUT'(d_i) + W_OUT'(prev_q);
    end
  end
endmodule

// File: rtl/cl_costas_pi.sv
`timescale 1ns/1ps
module cl_costas_pi #(
  parameter int OUT_W = 8,
  parameter int PW    = 16,
  parameter int KP_SH = 2,
  parameter int KI_SH = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OUT_W-1:0] i_i,
  input  logic signed [OUT_W-1:0] q_i,
  input  logic                    vld_i,
  output logic signed [PW-1:0]    pi_o
);
  localparam int ERR_W = OUT_W + 2;

  logic signed [ERR_W-1:0] ie, qe, t1, t2, err_d, err_q;
  logic                    err_vld_q;
  logic signed [PW-1:0]    err_w, integ_q, integ_n;

  assign ie = ERR_W'(i_i);
  assign qe = ERR_W'(q_i);

  always_comb begin
    t1 = (i_i > 0) ? qe : ((i_i < 0) ? -qe : '0);
    t2 = (q_i > 0) ? ie : ((q_i < 0) ? -ie : '0);
    err_d = t1 - t2;
  end

  assign err_w   = PW'(err_q);
  assign integ_n = integ_q + err_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      err_vld_q <= 1'b0;
      integ_q   <= '0;
      pi_o      <= '0;
    end else begin
      err_vld_q <= vld_i;
      if (vld_i) err_q <= err_d;
      if (err_vld_q) begin
        integ_q <= integ_n;
        pi_o    <= (err_w <<< KP_SH) + (integ_n <<< KI_SH);
      end
    end
  end

  // R5: loop output holds between error updates
  a_r5_pi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_q |=> $stable(pi_o));
endmodule

// File: rtl/cl_sweep.sv
`timescale 1ns/1ps
module cl_sweep #(
  parameter int PW    = 16,
  parameter int STEP  = 16,
  parameter int LIM   = 128
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  output logic signed [PW-1:0] sweep_o
);
  localparam logic signed [PW:0] STEP_V = (PW+1)'(STEP);
  localparam logic signed [PW:0] LIM_V  = (PW+1)'(LIM);

  logic             up_q;
  logic signed [PW:0] cur, nxt;

  assign cur = {sweep_o[PW-1], sweep_o};
  assign nxt = up_q ? cur + STEP_V : cur - STEP_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_o <= '0;
      up_q    <= 1'b1;
    end else if (step_i) begin
      if (up_q && nxt >= LIM_V) begin
        sweep_o <= PW'(LIM_V);
        up_q    <= 1'b0;
      end else if (!up_q && nxt <= -LIM_V) begin
        sweep_o <= PW'(-LIM_V);
        up_q    <= 1'b1;
      end else begin
        sweep_o <= PW'(nxt);
      end
    end
  end

  // R6: offset stays inside the search range
  a_r6_sweep_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur <= LIM_V) && (cur >= -LIM_V));
endmodule

// File: rtl/cl_lock_det.sv
`timescale 1ns/1ps
module cl_lock_det #(
  parameter int OUT_W    = 8,
  parameter int AVG_SH   = 1,
  parameter int LOCK_HI  = 24,
  parameter int LOCK_LO  = 8,
  parameter int LOCK_CNT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OUT_W-1:0] i_i,
  input  logic signed [OUT_W-1:0] q_i,
  input  logic                    vld_i,
  output logic                    lock_o
);
  localparam int AW = OUT_W + 4;
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam logic signed [AW-1:0] HI_V = AW'(LOCK_HI);
  localparam logic signed [AW-1:0] LO_V = AW'(LOCK_LO);

  logic signed [OUT_W:0] ie, qe;
  logic [OUT_W:0]        ai, aq, mn;
  logic signed [AW-1:0]  m_s, avg_q, avg_n;
  logic [CW-1:0]         cnt_q;

  assign ie  = {i_i[OUT_W-1], i_i};
  assign qe  = {q_i[OUT_W-1], q_i};
  assign ai  = ie[OUT_W] ? $unsigned(-ie) : $unsigned(ie);
  assign aq  = qe[OUT_W] ? $unsigned(-qe) : $unsigned(qe);
  assign mn  = (ai < aq) ? ai : aq;
  assign m_s = $signed({2'b00, mn, 1'b0});
  assign avg_n = avg_q + ((m_s - avg_q) >>> AVG_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q  <= '0;
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else if (vld_i) begin
      avg_q <= avg_n;
      if (lock_o) begin
        cnt_q <= '0;
        if (avg_n < LO_V) lock_o <= 1'b0;
      end else if (avg_n >= HI_V) begin
        if (int'(cnt_q) + 1 >= LOCK_CNT) begin
          lock_o <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R8: lock rises only on a metric update
  a_r8_rise_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(vld_i));
  // R9: lock drops only on a metric update
  a_r9_fall_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(vld_i));
endmodule

// File: rtl/carrier_loop.sv
`timescale 1ns/1ps
module carrier_loop #(
  parameter int IN_W       = 6,
  parameter int PW         = 16,
  parameter int NOM_INC    = 16384,
  parameter int KP_SH      = 2,
  parameter int KI_SH      = 0,
  parameter int SWEEP_STEP = 16,
  parameter int SWEEP_LIM  = 128,
  parameter int AVG_SH     = 1,
  parameter int LOCK_HI    = 24,
  parameter int LOCK_LO    = 8,
  parameter int LOCK_CNT   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IN_W-1:0]         sample_i,
  input  logic                    sample_valid_i,
  output logic signed [IN_W+1:0]  i_o,
  output logic signed [IN_W+1:0]  q_o,
  output logic                    iq_valid_o,
  output logic                    lock_o,
  output logic [PW-1:0]           freq_o
);
  localparam int MW    = IN_W + 1;
  localparam int OUT_W = IN_W + 2;

  logic signed [MW-1:0]    mix  [2];
  logic signed [OUT_W-1:0] filt [2];
  logic                    mix_vld, iq_vld_q;
  logic signed [PW-1:0]    sweep, pi;

  assign freq_o = PW'(NOM_INC) + $unsigned(sweep) + $unsigned(pi);

  cl_nco_mix #(.IN_W(IN_W), .PW(PW)) u_mix (
    .clk_i, .rst_ni, .sample_i, .valid_i(sample_valid_i), .freq_i(freq_o),
    .mix_i_o(mix[0]), .mix_q_o(mix[1]), .mix_vld_o(mix_vld));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    cl_boxcar2 #(.W_IN(MW), .W_OUT(OUT_W)) u_bx (
      .clk_i, .rst_ni, .d_i(mix[c]), .vld_i(mix_vld), .y_o(filt[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iq_vld_q <= 1'b0;
    else         iq_vld_q <= mix_vld;
  end

  assign i_o        = filt[0];
  assign q_o        = filt[1];
  assign iq_valid_o = iq_vld_q;

  cl_costas_pi #(.OUT_W(OUT_W), .PW(PW), .KP_SH(KP_SH), .KI_SH(KI_SH)) u_pi (
    .clk_i, .rst_ni, .i_i(filt[0]), .q_i(filt[1]), .vld_i(iq_vld_q), .pi_o(pi));

  cl_sweep #(.PW(PW), .STEP(SWEEP_STEP), .LIM(SWEEP_LIM)) u_sw (
    .clk_i, .rst_ni, .step_i(sample_valid_i && !lock_o), .sweep_o(sweep));

  cl_lock_det #(.OUT_W(OUT_W), .AVG_SH(AVG_SH), .LOCK_HI(LOCK_HI),
                .LOCK_LO(LOCK_LO), .LOCK_CNT(LOCK_CNT)) u_lk (
    .clk_i, .rst_ni, .i_i(filt[0]), .q_i(filt[1]), .vld_i(iq_vld_q), .lock_o);

  // R7: sweep frozen while locked
  a_r7_sweep_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && sample_valid_i) |=> $stable(sweep));
  // R2: filtered pair follows a sample by two edges
  a_r2_iq_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iq_valid_o |-> $past(sample_valid_i, 2));
endmodule

// File: tb/tb_carrier_loop.sv
`timescale 1ns/1ps
module tb_carrier_loop;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [5:0]        sample = 6'd32;
  logic              svld = 1'b0;
  logic signed [7:0] i_o, q_o;
  logic              iq_v, lock;
  logic [15:0]       freq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  carrier_loop dut (.clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .sample_valid_i(svld), .i_o(i_o), .q_o(q_o), .iq_valid_o(iq_v),
    .lock_o(lock), .freq_o(freq));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; svld = 1'b0; sample = 6'd32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one valid sample, ends on the negedge right after the sampling edge
  task automatic push(int din);
    sample = 6'(din); svld = 1'b1;
    @(negedge clk); svld = 1'b0; sample = 6'd32;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 i_o", int'(i_o), 0);
    chk("R10 q_o", int'(q_o), 0);
    chk("R10 iq_valid", int'(iq_v), 0);
    chk("R10 lock", int'(lock), 0);
    chk("R10/R4 freq", int'(freq), 16384);
  endtask

  task automatic t_mixer();
    do_reset();
    push(63);
    chk("R2 iq_valid one edge", int'(iq_v), 0);
    @(negedge clk);
    chk("R2 iq_valid two edges", int'(iq_v), 1);
    chk("R1 quad0 I", int'(i_o), 31);
    chk("R1 quad0 Q", int'(q_o), 0);
    @(negedge clk);
    chk("R2 iq_valid pulse", int'(iq_v), 0);
    settle();
    push(0); @(negedge clk);
    chk("R1/R2 quad1 I", int'(i_o), 31);
    chk("R1/R2 quad1 Q", int'(q_o), 32);
    settle();
    push(63); @(negedge clk);
    chk("R1/R3 quad2 I", int'(i_o), -31);
    chk("R1/R3 quad2 Q", int'(q_o), 32);
  endtask

  task automatic t_sweep();
    int sw = 0; bit up = 1;
    do_reset();
    for (int k = 0; k < 30; k++) begin
      push(32);
      if (up) begin sw += 16; if (sw >= 128) begin sw = 128; up = 0; end end
      else    begin sw -= 16; if (sw <= -128) begin sw = -128; up = 1; end end
      chk("R6 sweep step", int'(freq), 16384 + sw);
      repeat (2) @(negedge clk);
    end
    chk("R8 no lock on idle input", int'(lock), 0);
  endtask

  task automatic t_loop();
    do_reset();
    push(42); settle(); push(28); settle();
    chk("R5 negative error", int'(freq), 16384 + 32 - 30);
    do_reset();
    push(36); settle(); push(22); settle();
    chk("R5 positive error", int'(freq), 16384 + 32 + 30);
    push(32); settle();
    chk("R5 integral kept", int'(freq), 16384 + 48 + 6);
  endtask

  task automatic t_lock();
    int pat[4] = '{52, 12, 12, 52};
    do_reset();
    for (int k = 0; k < 10; k++) begin
      push(pat[k % 4]); settle();
      if (k == 4) chk("R8 not yet locked", int'(lock), 0);
      if (k == 5) begin
        chk("R8 lock after 4 updates", int'(lock), 1);
        chk("R6 sweep at lock", int'(freq), 16384 + 96);
      end
    end
    chk("R7 sweep frozen", int'(freq), 16384 + 96);
    push(32); settle(); push(32); settle();
    chk("R9 still locked", int'(lock), 1);
    push(32); settle();
    chk("R9 lock dropped", int'(lock), 0);
    chk("R7 frozen until drop", int'(freq), 16384 + 96);
    push(32); settle();
    chk("R7 sweep resumes", int'(freq), 16384 + 112);
  endtask

  initial begin
    t_reset();
    t_mixer();
    t_sweep();
    t_loop();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule